// File: doc/BRIEF.md
# Quadrature DC Offset Calibration Sequencer

This block drives a closed-loop routine that removes the DC offset from the I and Q transmit outputs of an external quadrature upconverter. The upconverter has one analog monitor pin that can present a reference level or an error level for either channel. It also has a low-gain and a high-gain measurement mode. The sequencer picks the monitor source and the gain mode through a strobed command port. It waits a symbol-timed delay and requests one auxiliary ADC conversion. It then turns the reading into a correction for a signed offset register, one per channel.

A run starts from a start pulse. First come an initialisation pulse and two reference reads, I and then Q. Next is a damped low-gain pass that corrects I and then Q. This pass repeats with a settling pause in between. After that the block switches to high gain and adds a fixed carry-over offset to both channels. It then repeats damped passes that correct Q before I. Finally it returns the monitor to its idle selection and raises a one-cycle done pulse. Each correction is the measured error, less the reference of the same channel, scaled by a fractional loop gain. Because the gain of the analog path is not known, several damped passes converge where one full step could not.

Top module: `dcoff_cal_seq`

## Requirements
- R1: After reset `busy`, `done`, `adc_req`, `mon_stb` and both offsets are 0. A `start` pulse while idle begins a run, and `busy` stays 1 until the cycle after the one-cycle `done` pulse. A `start` while busy has no effect: the read count and the done count of the run stay unchanged.
- R2: ADC reads happen in this order of `mon_sel` codes (0 = I reference, 1 = Q reference, 2 = I error, 3 = Q error). First come 0 and 1. Then come N low-gain passes of 2 and 3. Then come N high-gain passes of 3 and 2. `mon_hg` is 0 for the first two groups and 1 for the high-gain passes.
- R3: Each run gives exactly one `mon_init` pulse, and it comes before any `mon_stb`. Every ADC read is preceded by its own `mon_stb`. One more `mon_stb` comes for the gain switch and one for the restore, so a run has reads+2 strobes.
- R4: `adc_req` is a one-cycle pulse. It rises exactly D cycles after the `mon_stb` of its read. With S = `cfg_sym`, D = S + floor(S/5) when `cfg_slow` is 0 and D = 8S + floor(S/5) when `cfg_slow` is 1.
- R5: `start` clears both offsets. The reading on an error read, minus the reference read earlier for that channel, is multiplied by `cfg_gain`/256 and floored. The result is subtracted from that channel's offset, which is visible the cycle after `adc_vld`. Offsets do not change at any other time, apart from R9.
- R6: Every offset update saturates at +32767 and -32768 and never wraps.
- R7: N equals `cfg_iters`, except that a value of 0 gives one pass.
- R8: Between passes, the `mon_stb` that starts the next pass comes 4S+2 cycles after the `adc_vld` of the previous read. Within a pass, the next `mon_stb` follows `adc_vld` by 1 cycle.
- R9: After the low-gain passes, one `mon_stb` with `mon_hg`=1 is issued. In that cycle `cfg_lohi` is added, with saturation, to both offsets.
- R10: The last action of a run is a `mon_stb` with `mon_sel`=0 and `mon_hg`=0. `done` follows it by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (pulse) |
| cfg_iters | input | 4 | Passes per gain phase (0 means 1) |
| cfg_gain | input | 8 | Loop gain, unsigned, value/256 |
| cfg_slow | input | 1 | Sample delay select: 0 short, 1 long |
| cfg_sym | input | 12 | Symbol period in clock cycles |
| cfg_lohi | input | 16 | Signed offset added on the gain switch |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mon_init | output | 1 | Initialise serial port and ADC (pulse) |
| mon_stb | output | 1 | Apply `mon_sel` and `mon_hg` to the upconverter (pulse) |
| mon_sel | output | 2 | Monitor source code |
| mon_hg | output | 1 | High-gain measurement mode |
| adc_req | output | 1 | Conversion request (pulse) |
| adc_vld | input | 1 | Conversion result valid |
| adc_data | input | 12 | Signed conversion result |
| off_i | output | 16 | Signed I offset |
| off_q | output | 16 | Signed Q offset |

## Verification
The assertions take for granted that `adc_vld` comes only as the single answer to an outstanding request, at least one cycle after `adc_req`. They also assume that `cfg_sym` is nonzero and that the configuration inputs do not change while `busy` is high. The bench answers each request exactly two cycles later and never on its own. It changes the configuration only between runs and uses symbol periods of ten cycles and more. The one `start` it gives during a run comes while the sequencer is waiting on a delay.

// File: rtl/dcoff_pkg.sv
package dcoff_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_REF_I, ST_REF_Q, ST_ERR_I_LO, ST_ERR_Q_LO,
    ST_SETTLE_LO, ST_HIGH, ST_ERR_Q_HI, ST_ERR_I_HI, ST_SETTLE_HI,
    ST_TIDY, ST_FIN
  } cal_state_e;

  typedef enum logic [1:0] {PH_SEL, PH_WAIT, PH_ADC} cal_phase_e;

  localparam logic [1:0] MON_REF_I = 2'd0;
  localparam logic [1:0] MON_REF_Q = 2'd1;
  localparam logic [1:0] MON_ERR_I = 2'd2;
  localparam logic [1:0] MON_ERR_Q = 2'd3;

  function automatic logic is_meas(cal_state_e s);
    return (s == ST_REF_I) || (s == ST_REF_Q) || (s == ST_ERR_I_LO) ||
           (s == ST_ERR_Q_LO) || (s == ST_ERR_Q_HI) || (s == ST_ERR_I_HI);
  endfunction

  function automatic logic is_settle(cal_state_e s);
    return (s == ST_SETTLE_LO) || (s == ST_SETTLE_HI);
  endfunction

  // monitor source presented while in a given stage
  function automatic logic [1:0] mon_code(cal_state_e s);
    case (s)
      ST_REF_Q:                              return MON_REF_Q;
      ST_ERR_I_LO, ST_ERR_I_HI, ST_SETTLE_HI: return MON_ERR_I;
      ST_ERR_Q_LO, ST_ERR_Q_HI, ST_SETTLE_LO, ST_HIGH: return MON_ERR_Q;
      default:                               return MON_REF_I;
    endcase
  endfunction

  function automatic logic mon_high(cal_state_e s);
    return (s == ST_HIGH) || (s == ST_ERR_Q_HI) || (s == ST_ERR_I_HI) ||
           (s == ST_SETTLE_HI);
  endfunction

  // stage after a completed read; last selects leaving the pass loop
  function automatic cal_state_e after_meas(cal_state_e s, logic last);
    case (s)
      ST_REF_I:    return ST_REF_Q;
      ST_REF_Q:    return ST_ERR_I_LO;
      ST_ERR_I_LO: return ST_ERR_Q_LO;
      ST_ERR_Q_LO: return last ? ST_HIGH : ST_SETTLE_LO;
      ST_ERR_Q_HI: return ST_ERR_I_HI;
      ST_ERR_I_HI: return last ? ST_TIDY : ST_SETTLE_HI;
      default:     return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dcoff_delay.sv
module dcoff_delay #(
  parameter int SYM_W      = 12,
  parameter int SETTLE_SYM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             settle,
  input  logic             slow,
  input  logic [SYM_W-1:0] sym,
  output logic             zero
);
  localparam int CNT_W = SYM_W + 4 + $clog2(SETTLE_SYM + 1);

  // cycles before a sample: one or eight symbols plus a fifth of a symbol
  function automatic logic [CNT_W-1:0] samp_len(logic [SYM_W-1:0] s, logic lg);
    logic [CNT_W-1:0] w;
    w = CNT_W'(s);
    return (lg ? (w << 3) : w) + (w / CNT_W'(5));
  endfunction

  function automatic logic [CNT_W-1:0] settle_len(logic [SYM_W-1:0] s);
    return CNT_W'(s) * CNT_W'(SETTLE_SYM);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  assign len  = settle ? settle_len(sym) : samp_len(sym, slow);
  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dcoff_chan.sv
module dcoff_chan #(
  parameter int OFF_W  = 16,
  parameter int ADC_W  = 12,
  parameter int GAIN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     ref_ld,
  input  logic                     upd,
  input  logic                     add,
  input  logic signed [ADC_W-1:0]  adc,
  input  logic        [GAIN_W-1:0] gain,
  input  logic signed [OFF_W-1:0]  lohi,
  output logic signed [OFF_W-1:0]  off
);
  localparam int EXT_W = OFF_W + ADC_W + GAIN_W + 2;
  localparam logic signed [EXT_W-1:0] MAXV = {{(EXT_W-OFF_W+1){1'b0}}, {(OFF_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MINV = {{(EXT_W-OFF_W+1){1'b1}}, {(OFF_W-1){1'b0}}};

  function automatic logic signed [OFF_W-1:0] clamp(logic signed [EXT_W-1:0] v);
    if (v > MAXV)      return MAXV[OFF_W-1:0];
    else if (v < MINV) return MINV[OFF_W-1:0];
    else               return v[OFF_W-1:0];
  endfunction

  // floor((sample - reference) * gain / 2^GAIN_W)
  function automatic logic signed [EXT_W-1:0] correction(
      logic signed [ADC_W-1:0] s, logic signed [ADC_W-1:0] r, logic [GAIN_W-1:0] g);
    logic signed [EXT_W-1:0] a, b, k, p;
    a = s;
    b = r;
    k = $signed({{(EXT_W-GAIN_W){1'b0}}, g});
    p = (a - b) * k;
    return p >>> GAIN_W;
  endfunction

  logic signed [ADC_W-1:0] ref_r;
  logic signed [OFF_W-1:0] off_r;
  logic signed [EXT_W-1:0] off_x, lohi_x, corr;

  assign off_x  = off_r;
  assign lohi_x = lohi;
  assign corr   = correction(adc, ref_r, gain);
  assign off    = off_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_r <= '0;
    else if (ref_ld) ref_r <= adc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_r <= '0;
    else if (clr)  off_r <= '0;
    else if (upd)  off_r <= clamp(off_x - corr);
    else if (add)  off_r <= clamp(off_x + lohi_x);
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd && !add) |=> $stable(off_r));

  assert_sat_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr && !upd && !lohi[OFF_W-1]) |=> (off_r >= $past(off_r)));

  assert_sat_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr && !upd && lohi[OFF_W-1]) |=> (off_r <= $past(off_r)));

endmodule

// File: rtl/dcoff_fsm.sv
module dcoff_fsm
  import dcoff_pkg::*;
#(
  parameter int ITER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adc_vld,
  input  logic              tmr_zero,
  input  logic [ITER_W-1:0] cfg_iters,
  output logic              busy,
  output logic              done,
  output logic              cmd_init,
  output logic              cmd_stb,
  output logic              adc_req,
  output logic              tmr_load,
  output logic              tmr_settle,
  output logic              clr,
  output logic              add_lohi,
  output logic [1:0]        mon_sel,
  output logic              mon_hg,
  output logic [1:0]        ref_ld,
  output logic [1:0]        upd
);
  cal_state_e        st, st_nx;
  cal_phase_e        ph, ph_nx;
  logic [ITER_W-1:0] pass_cnt, pass_nx;
  logic [ITER_W:0]   need;
  logic              last_pass;
  logic              rd_done;
  logic              meas, sett;

  assign need      = (cfg_iters == '0) ? (ITER_W+1)'(1) : {1'b0, cfg_iters};
  assign last_pass = ({1'b0, pass_cnt} + (ITER_W+1)'(1)) >= need;
  assign meas      = is_meas(st);
  assign sett      = is_settle(st);
  assign rd_done   = meas && (ph == PH_ADC) && adc_vld;

  always_comb begin
    st_nx   = st;
    ph_nx   = ph;
    pass_nx = pass_cnt;
    case (st)
      ST_IDLE:  if (start) begin st_nx = ST_SETUP; ph_nx = PH_SEL; end
      ST_SETUP: begin st_nx = ST_REF_I;    pass_nx = '0; end
      ST_HIGH:  begin st_nx = ST_ERR_Q_HI; pass_nx = '0; end
      ST_TIDY:  st_nx = ST_FIN;
      ST_FIN:   st_nx = ST_IDLE;
      default: begin
        if (ph == PH_SEL) begin
          ph_nx = PH_WAIT;
        end else if (ph == PH_WAIT) begin
          if (tmr_zero) begin
            if (sett) begin
              st_nx = (st == ST_SETTLE_LO) ? ST_ERR_I_LO : ST_ERR_Q_HI;
              ph_nx = PH_SEL;
            end else begin
              ph_nx = PH_ADC;
            end
          end
        end else if (adc_vld) begin
          st_nx = after_meas(st, last_pass);
          ph_nx = PH_SEL;
          if (st == ST_ERR_Q_LO || st == ST_ERR_I_HI) pass_nx = pass_cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_SEL;
      pass_cnt <= '0;
    end else begin
      st       <= st_nx;
      ph       <= ph_nx;
      pass_cnt <= pass_nx;
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_FIN);
  assign cmd_init   = (st == ST_SETUP);
  assign cmd_stb    = (meas && ph == PH_SEL) || (st == ST_HIGH) || (st == ST_TIDY);
  assign adc_req    = meas && (ph == PH_WAIT) && tmr_zero;
  assign tmr_load   = (meas || sett) && (ph == PH_SEL);
  assign tmr_settle = sett;
  assign clr        = (st == ST_SETUP);
  assign add_lohi   = (st == ST_HIGH);
  assign mon_sel    = mon_code(st);
  assign mon_hg     = mon_high(st);
  assign ref_ld[0]  = rd_done && (st == ST_REF_I);
  assign ref_ld[1]  = rd_done && (st == ST_REF_Q);
  assign upd[0]     = rd_done && (st == ST_ERR_I_LO || st == ST_ERR_I_HI);
  assign upd[1]     = rd_done && (st == ST_ERR_Q_LO || st == ST_ERR_Q_HI);

  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> !adc_req);

  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_init, cmd_stb, adc_req, done}));

  assert_done_restored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cmd_stb) && !$past(mon_hg) && ($past(mon_sel) == MON_REF_I)));

  assert_hg_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    add_lohi |-> (cmd_stb && mon_hg));

endmodule

// File: rtl/dcoff_cal_seq.sv
module dcoff_cal_seq #(
  parameter int OFF_W      = 16,
  parameter int ADC_W      = 12,
  parameter int GAIN_W     = 8,
  parameter int ITER_W     = 4,
  parameter int SYM_W      = 12,
  parameter int SETTLE_SYM = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ITER_W-1:0]        cfg_iters,
  input  logic [GAIN_W-1:0]        cfg_gain,
  input  logic                     cfg_slow,
  input  logic [SYM_W-1:0]         cfg_sym,
  input  logic signed [OFF_W-1:0]  cfg_lohi,
  output logic                     busy,
  output logic                     done,
  output logic                     mon_init,
  output logic                     mon_stb,
  output logic [1:0]               mon_sel,
  output logic                     mon_hg,
  output logic                     adc_req,
  input  logic                     adc_vld,
  input  logic signed [ADC_W-1:0]  adc_data,
  output logic signed [OFF_W-1:0]  off_i,
  output logic signed [OFF_W-1:0]  off_q
);
  localparam int NCH = 2;

  logic              tmr_zero, tmr_load, tmr_settle;
  logic              clr, add_lohi;
  logic [NCH-1:0]    ref_ld, upd;
  logic signed [OFF_W-1:0] off_v [NCH];

  dcoff_fsm #(.ITER_W(ITER_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_vld(adc_vld),
    .tmr_zero(tmr_zero), .cfg_iters(cfg_iters), .busy(busy), .done(done),
    .cmd_init(mon_init), .cmd_stb(mon_stb), .adc_req(adc_req),
    .tmr_load(tmr_load), .tmr_settle(tmr_settle), .clr(clr),
    .add_lohi(add_lohi), .mon_sel(mon_sel), .mon_hg(mon_hg),
    .ref_ld(ref_ld), .upd(upd)
  );

  dcoff_delay #(.SYM_W(SYM_W), .SETTLE_SYM(SETTLE_SYM)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .settle(tmr_settle),
    .slow(cfg_slow), .sym(cfg_sym), .zero(tmr_zero)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dcoff_chan #(.OFF_W(OFF_W), .ADC_W(ADC_W), .GAIN_W(GAIN_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ref_ld(ref_ld[c]), .upd(upd[c]),
      .add(add_lohi), .adc(adc_data), .gain(cfg_gain), .lohi(cfg_lohi),
      .off(off_v[c])
    );
  end

  assign off_i = off_v[0];
  assign off_q = off_v[1];

  assert_clear_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mon_init |=> (off_i == '0 && off_q == '0));

endmodule

// File: tb/sim_dcoff_cal_seq.sv
`timescale 1ns/1ps
module sim_dcoff_cal_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] cfg_iters = 0;
  logic [7:0] cfg_gain = 0;
  logic cfg_slow = 0;
  logic [11:0] cfg_sym = 20;
  logic signed [15:0] cfg_lohi = 0;
  logic busy, done, mon_init, mon_stb, mon_hg, adc_req, adc_vld = 0;
  logic [1:0] mon_sel;
  logic signed [11:0] adc_data = 0;
  logic signed [15:0] off_i, off_q;

  dcoff_cal_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .cfg_iters(cfg_iters),
    .cfg_gain(cfg_gain), .cfg_slow(cfg_slow), .cfg_sym(cfg_sym), .cfg_lohi(cfg_lohi),
    .busy(busy), .done(done), .mon_init(mon_init), .mon_stb(mon_stb),
    .mon_sel(mon_sel), .mon_hg(mon_hg), .adc_req(adc_req), .adc_vld(adc_vld),
    .adc_data(adc_data), .off_i(off_i), .off_q(off_q));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // analog model of the monitor pin
  int RI = 100, RQ = -60, DCI = 0, DCQ = 0, SHIFT = 200;
  int k_rd = 0, n_cmd = 0, n_init = 0, n_done = 0, init_cyc = 0, done_cyc = 0, last_cmd = 0;
  int rd_sel[64], rd_hg[64], rd_cmd[64], rd_req[64], rd_vld[64];

  function automatic int clip12(int v);
    return (v > 2047) ? 2047 : (v < -2048) ? -2048 : v;
  endfunction
  function automatic int sat16(int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction
  function automatic int fl256(int p);
    return (p >= 0) ? p / 256 : -((-p + 255) / 256);
  endfunction
  function automatic int adc_model(int sel, int hg, int oi, int oq);
    case (sel)
      0: return clip12(RI);
      1: return clip12(RQ);
      2: return clip12(RI + (hg != 0 ? (oi - DCI - SHIFT) : (oi - DCI) / 4));
      default: return clip12(RQ + (hg != 0 ? (oq - DCQ - SHIFT) : (oq - DCQ) / 4));
    endcase
  endfunction

  int pend = 0, resp = 0;
  initial forever begin
    @(negedge clk);
    adc_vld = 0;
    if (pend == 1) begin adc_vld = 1; adc_data = 12'(resp); rd_vld[k_rd-1] = cyc; end
    if (pend > 0) pend--;
    if (mon_init) begin n_init++; init_cyc = cyc; end
    if (mon_stb) begin n_cmd++; last_cmd = cyc; end
    if (done) begin n_done++; done_cyc = cyc; end
    if (adc_req && k_rd < 64) begin
      rd_sel[k_rd] = mon_sel; rd_hg[k_rd] = mon_hg;
      rd_cmd[k_rd] = last_cmd; rd_req[k_rd] = cyc;
      resp = adc_model(mon_sel, mon_hg, off_i, off_q);
      k_rd++; pend = 2;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  function automatic int passes(int it); return (it == 0) ? 1 : it; endfunction

  task automatic expect_offs(input int n, input int g, input int lohi, output int ei, output int eq);
    int oi = 0, oq = 0, ri, rq, e;
    ri = adc_model(0, 0, 0, 0); rq = adc_model(1, 0, 0, 0);
    for (int p = 0; p < n; p++) begin
      e = adc_model(2, 0, oi, oq) - ri; oi = sat16(oi - fl256(e * g));
      e = adc_model(3, 0, oi, oq) - rq; oq = sat16(oq - fl256(e * g));
    end
    oi = sat16(oi + lohi); oq = sat16(oq + lohi);
    for (int p = 0; p < n; p++) begin
      e = adc_model(3, 1, oi, oq) - rq; oq = sat16(oq - fl256(e * g));
      e = adc_model(2, 1, oi, oq) - ri; oi = sat16(oi - fl256(e * g));
    end
    ei = oi; eq = oq;
  endtask

  task automatic run_cal(input int it, input int g, input bit sl, input int sym, input int lohi,
                         input int poke_at);
    @(negedge clk);
    cfg_iters = 4'(it); cfg_gain = 8'(g); cfg_slow = sl; cfg_sym = 12'(sym);
    cfg_lohi = 16'(lohi);
    k_rd = 0; n_cmd = 0; n_init = 0; n_done = 0;
    start = 1; @(negedge clk); start = 0;
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (n_done == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_order(input int n, input string tag);
    int es, eh;
    chk(k_rd == 2 + 4 * n, {tag, " read count"}, k_rd, 2 + 4 * n);
    for (int k = 0; k < k_rd && k < 2 + 4 * n; k++) begin
      if (k < 2) begin es = k; eh = 0; end
      else if (k < 2 + 2 * n) begin es = ((k - 2) % 2 == 0) ? 2 : 3; eh = 0; end
      else begin es = ((k - 2 - 2 * n) % 2 == 0) ? 3 : 2; eh = 1; end
      chk(rd_sel[k] == es && rd_hg[k] == eh, {tag, " R2 sel/hg order"},
          rd_sel[k] * 10 + rd_hg[k], es * 10 + eh);
    end
  endtask

  task automatic check_offs(input int n, input int g, input int lohi, input string tag);
    int ei, eq;
    expect_offs(n, g, lohi, ei, eq);
    chk(off_i == 16'(ei), {tag, " R5 R9 off_i"}, off_i, ei);
    chk(off_q == 16'(eq), {tag, " R5 R9 off_q"}, off_q, eq);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !adc_req && !mon_stb, "R1 reset strobes", busy, 0);
    chk(off_i == 0 && off_q == 0, "R1 reset offsets", off_i, 0);
  endtask

  task automatic t_basic();
    int d = 20 + 4;
    DCI = 300; DCQ = -250;
    run_cal(2, 128, 0, 20, 180, 0);
    check_order(2, "basic");
    check_offs(2, 128, 180, "basic");
    chk(n_init == 1 && init_cyc < rd_cmd[0], "R3 init pulse", n_init, 1);
    chk(n_cmd == k_rd + 2, "R3 strobe count", n_cmd, k_rd + 2);
    for (int k = 0; k < k_rd; k++)
      chk(rd_req[k] - rd_cmd[k] == d, "R4 fast sample delay", rd_req[k] - rd_cmd[k], d);
    chk(n_done == 1 && done_cyc - last_cmd == 1, "R10 done after restore", done_cyc - last_cmd, 1);
    chk(mon_sel == 0 && !mon_hg && !busy, "R10 monitor restored", mon_sel, 0);
    chk(rd_hg[6] == 1 && rd_hg[5] == 0, "R9 gain switch", rd_hg[6], 1);
  endtask

  task automatic t_single();
    DCI = -500; DCQ = 700;
    run_cal(0, 200, 0, 15, -90, 0);
    check_order(1, "R7 zero iters");
    check_offs(1, 200, -90, "R7 zero iters");
  endtask

  task automatic t_slow_settle();
    int d = 80 + 2, t = 40;
    DCI = 1000; DCQ = 40;
    run_cal(3, 96, 1, 10, 150, 0);
    check_order(3, "R7 three iters");
    check_offs(3, 96, 150, "slow");
    chk(rd_req[0] - rd_cmd[0] == d, "R4 slow sample delay", rd_req[0] - rd_cmd[0], d);
    chk(rd_req[9] - rd_cmd[9] == d, "R4 slow sample delay hi", rd_req[9] - rd_cmd[9], d);
    chk(rd_cmd[4] - rd_vld[3] == t + 2, "R8 settle lo", rd_cmd[4] - rd_vld[3], t + 2);
    chk(rd_cmd[10] - rd_vld[9] == t + 2, "R8 settle hi", rd_cmd[10] - rd_vld[9], t + 2);
    chk(rd_cmd[3] - rd_vld[2] == 1, "R8 in-pass gap", rd_cmd[3] - rd_vld[2], 1);
  endtask

  task automatic t_sat();
    DCI = 40000; DCQ = 40000;
    run_cal(8, 255, 0, 10, 30000, 0);
    chk(off_i == 16'sd32767 && off_q == 16'sd32767, "R6 high clamp", off_i, 32767);
    check_offs(8, 255, 30000, "R6 high");
    DCI = -40000; DCQ = -40000;
    run_cal(8, 255, 0, 10, -30000, 0);
    chk(off_i == -16'sd32768 && off_q == -16'sd32768, "R6 low clamp", off_q, -32768);
    check_offs(8, 255, -30000, "R6 low");
  endtask

  task automatic t_restart_ignored();
    DCI = 120; DCQ = -80;
    run_cal(2, 128, 0, 20, 60, 60);
    chk(k_rd == 10, "R1 start while busy read count", k_rd, 10);
    chk(n_done == 1 && n_init == 1, "R1 start while busy single run", n_done, 1);
    check_offs(2, 128, 60, "R1 restart");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_basic();
    t_single();
    t_slow_settle();
    t_sat();
    t_restart_ignored();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R1 watchdog expired actual=busy expected=idle");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule